// File: doc/BRIEF.md
# SPI Control Register and Bit-Clock Prescaler

This block is the control front end of a serial peripheral port. It holds one byte-wide control register that the system bus can write. The register carries an interrupt enable, a port enable, an open-drain select and a three-bit rate code. From these fields the block derives four things: a bit-clock strobe at a power-of-two fraction of the system clock, a clock-gate enable for the shifter, one interrupt request, and per-pad drive controls.

The shifter consumes `bit_tick_o` as a one-cycle clock enable. It receives `port_clk_en_o` as the enable for its local clock gate. It sends back its transfer-done and mode-fault flags. The block combines those flags into a registered interrupt request, subject to the interrupt enable. Each pad gets an output value and an output enable. In push-pull mode the pad drives both levels. In open-drain mode a logic 1 releases the pad and a logic 0 pulls it low.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset, all of the following are 0: the register readback, `irq_o`, `bit_tick_o`, `port_clk_en_o` and every pad enable.
- R2: A write stores bit 7 as the interrupt enable, bit 6 as the port enable, bit 5 as the open-drain select and bits 2:0 as the rate code. Readback returns these same bits in the same positions, with bits 4:3 always read as 0.
- R3: With the port enabled, rate code k (0 to 7) gives a divide of N = 2^k. The first `bit_tick_o` pulse falls in the N-th cycle after the write edge, and later pulses follow every N cycles. Code 0 pulses every cycle and code 7 divides by 128.
- R4: Any register write restarts the prescaler count from zero, so the next pulse comes a full N cycles after that write.
- R5: While the port enable is 0, `bit_tick_o`, `port_clk_en_o` and all pad enables stay 0.
- R6: With the interrupt enable set, `irq_o` rises on the clock edge after either the done flag or the fault flag is high.
- R7: Clearing the interrupt enable drops `irq_o` within one clock, even while a flag stays high. The request does not return until the enable is set again.
- R8: In push-pull mode with the port enabled, every pad enable is 1 and each pad value equals its output data bit.
- R9: In open-drain mode with the port enabled, every pad value is 0 and each pad enable is the inverse of its output data bit.
- R10: With the interrupt enable set, `irq_o` falls on the clock edge after both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register readback |
| done_flag_i | input | 1 | Transfer-done flag from shifter |
| fault_flag_i | input | 1 | Mode-fault flag from shifter |
| irq_o | output | 1 | Registered interrupt request |
| bit_tick_o | output | 1 | Bit-clock enable strobe |
| port_clk_en_o | output | 1 | Clock-gate enable for the shifter |
| pad_out_i | input | NUM_PADS | Output data per pad |
| pad_o | output | NUM_PADS | Pad output value |
| pad_oe_o | output | NUM_PADS | Pad output enable |

## Verification
A wrong prescaler count shows up on `bit_tick_o` as a changed interval. A count that is not cleared on a write shows up as an early first pulse. Both are visible within one divide period, at most 128 cycles. A stale interrupt-enable or request register shows at `irq_o` one edge after the flags or the enable change. A wrong mode bit appears at once on the pad enables and values. The bench therefore measures the exact cycle of the first and second tick for several rate codes, including after a mid-count rewrite. It also samples `irq_o` on the first and second cycle after each change, and checks the pads in both modes against complementary data patterns.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int RATE_W = 3;
  localparam int REG_W  = 8;
  localparam int CNT_W  = (1 << RATE_W) - 1;

  localparam int BIT_IRQ_EN  = 7;
  localparam int BIT_PORT_EN = 6;
  localparam int BIT_OD_EN   = 5;

  typedef struct packed {
    logic              irq_en;
    logic              port_en;
    logic              od_en;
    logic [RATE_W-1:0] rate;
  } ctl_t;
endpackage

// File: rtl/spi_ctl_reg.sv
module spi_ctl_reg
  import spi_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output ctl_t             ctl_o,
  output logic [REG_W-1:0] rd_data_o
);
  ctl_t ctl_q;
  logic unused_wr;

  assign unused_wr = ^wr_data_i[BIT_OD_EN-1:RATE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (wr_en_i) begin
      ctl_q.irq_en  <= wr_data_i[BIT_IRQ_EN];
      ctl_q.port_en <= wr_data_i[BIT_PORT_EN];
      ctl_q.od_en   <= wr_data_i[BIT_OD_EN];
      ctl_q.rate    <= wr_data_i[RATE_W-1:0];
    end
  end

  always_comb begin
    rd_data_o                 = '0;
    rd_data_o[BIT_IRQ_EN]     = ctl_q.irq_en;
    rd_data_o[BIT_PORT_EN]    = ctl_q.port_en;
    rd_data_o[BIT_OD_EN]      = ctl_q.od_en;
    rd_data_o[RATE_W-1:0]     = ctl_q.rate;
  end

  assign ctl_o = ctl_q;

  // R2: a write is visible on readback after the edge
  a_r2_write_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[BIT_IRQ_EN:BIT_OD_EN] == $past(wr_data_i[BIT_IRQ_EN:BIT_OD_EN])) &&
                (rd_data_o[RATE_W-1:0] == $past(wr_data_i[RATE_W-1:0])));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/spi_ctl_prescaler.sv
module spi_ctl_prescaler
  import spi_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign span     = (CNT_W+1)'(1) << rate_i;
  assign limit    = CNT_W'(span - (CNT_W+1)'(1));
  assign at_limit = (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || restart_i || at_limit) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = en_i && at_limit;

  a_r5_no_tick_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);
  // R4: the cycle after a restart holds a tick only for divide by 1
  a_r4_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && en_i && $stable(rate_i) && rate_i != '0) |=> !tick_o);
  a_r3_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && rate_i != '0 && !restart_i) |=> !tick_o);
endmodule

// File: rtl/spi_ctl_irq.sv
module spi_ctl_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_en_i,
  input  logic done_i,
  input  logic fault_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_en_i && (done_i || fault_i);
  end

  assign irq_o = irq_q;

  a_r6_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && (done_i || fault_i)) |=> irq_o);
  a_r7_drop_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> !irq_o);
  a_r10_drop_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !fault_i) |=> !irq_o);
endmodule

// File: rtl/spi_ctl_pad.sv
module spi_ctl_pad #(
  parameter int NUM_PADS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                port_en_i,
  input  logic                od_en_i,
  input  logic [NUM_PADS-1:0] data_i,
  output logic [NUM_PADS-1:0] pad_o,
  output logic [NUM_PADS-1:0] oe_o
);
  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    always_comb begin
      if (!port_en_i) begin
        pad_o[i] = 1'b0;
        oe_o[i]  = 1'b0;
      end else if (od_en_i) begin
        pad_o[i] = 1'b0;
        oe_o[i]  = !data_i[i];
      end else begin
        pad_o[i] = data_i[i];
        oe_o[i]  = 1'b1;
      end
    end

    a_r9_od_never_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      od_en_i |-> !(oe_o[i] && pad_o[i]));
    a_r5_released_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !port_en_i |-> !oe_o[i]);
    a_r8_pushpull_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (port_en_i && !od_en_i) |-> oe_o[i]);
  end
endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
  import spi_ctl_pkg::*;
#(
  parameter int NUM_PADS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_data_i,
  output logic [REG_W-1:0]    rd_data_o,
  input  logic                done_flag_i,
  input  logic                fault_flag_i,
  output logic                irq_o,
  output logic                bit_tick_o,
  output logic                port_clk_en_o,
  input  logic [NUM_PADS-1:0] pad_out_i,
  output logic [NUM_PADS-1:0] pad_o,
  output logic [NUM_PADS-1:0] pad_oe_o
);
  ctl_t ctl;

  spi_ctl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctl_o     (ctl),
    .rd_data_o (rd_data_o)
  );

  spi_ctl_prescaler u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ctl.port_en),
    .restart_i (wr_en_i),
    .rate_i    (ctl.rate),
    .tick_o    (bit_tick_o)
  );

  spi_ctl_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_en_i (ctl.irq_en),
    .done_i   (done_flag_i),
    .fault_i  (fault_flag_i),
    .irq_o    (irq_o)
  );

  spi_ctl_pad #(.NUM_PADS(NUM_PADS)) u_pad (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .port_en_i (ctl.port_en),
    .od_en_i   (ctl.od_en),
    .data_i    (pad_out_i),
    .pad_o     (pad_o),
    .oe_o      (pad_oe_o)
  );

  assign port_clk_en_o = ctl.port_en;

  a_r5_gate_follows_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_clk_en_o |-> (!bit_tick_o && pad_oe_o == '0));
endmodule

// File: tb/sim_spi_ctl_top.sv
module sim_spi_ctl_top;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;
  logic          done_f = 1'b0;
  logic          fault_f = 1'b0;
  logic          irq;
  logic          tick;
  logic          clk_en;
  logic [NP-1:0] pad_out = '0;
  logic [NP-1:0] pad;
  logic [NP-1:0] pad_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  spi_ctl_top #(.NUM_PADS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .done_flag_i(done_f), .fault_flag_i(fault_f),
    .irq_o(irq), .bit_tick_o(tick), .port_clk_en_o(clk_en),
    .pad_out_i(pad_out), .pad_o(pad), .pad_oe_o(pad_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Leaves the caller at the first negedge after the write edge.
  task automatic reg_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 readback", rd_data, 0);
    check("R1 irq", irq, 0);
    check("R1 tick", tick, 0);
    check("R1 clk_en", clk_en, 0);
    check("R1 oe", pad_oe, 0);
  endtask

  task automatic t_readback;
    reg_write(8'hFF);
    check("R2 all ones", rd_data, 8'hE7);
    reg_write(8'h9A);
    check("R2 pattern", rd_data, 8'h82);
    reg_write(8'h00);
    check("R2 zero", rd_data, 0);
  endtask

  // First tick expected at sample n, second at 2n.
  task automatic t_divide(input int code);
    int n;
    int first;
    int second;
    n = 1 << code;
    first = 0;
    second = 0;
    reg_write(8'h40 | 8'(code));
    for (int s = 1; s <= 2 * n + 2; s++) begin
      if (s > 1) @(negedge clk);
      if (tick) begin
        if (first == 0) first = s;
        else if (second == 0) second = s;
      end
    end
    check($sformatf("R3 first tick code %0d", code), first, n);
    check($sformatf("R3 second tick code %0d", code), second, 2 * n);
  endtask

  task automatic t_restart;
    int first;
    first = 0;
    reg_write(8'h43);
    repeat (5) @(negedge clk);
    reg_write(8'h43);
    for (int s = 1; s <= 10; s++) begin
      if (s > 1) @(negedge clk);
      if (tick && first == 0) first = s;
    end
    check("R4 restart on write", first, 8);
  endtask

  task automatic t_disabled;
    int seen;
    seen = 0;
    pad_out = 4'b1010;
    reg_write(8'h00);
    for (int s = 0; s < 300; s++) begin
      if (tick) seen++;
      @(negedge clk);
    end
    check("R5 no tick", seen, 0);
    check("R5 clk_en", clk_en, 0);
    check("R5 oe", pad_oe, 0);
    reg_write(8'h20);
    check("R5 oe od off", pad_oe, 0);
  endtask

  task automatic t_irq;
    reg_write(8'h80);
    check("R6 idle", irq, 0);
    done_f = 1'b1;
    @(negedge clk);
    check("R6 done", irq, 1);
    done_f = 1'b0;
    @(negedge clk);
    check("R10 clear", irq, 0);
    fault_f = 1'b1;
    @(negedge clk);
    check("R6 fault", irq, 1);
    reg_write(8'h00);
    @(negedge clk);
    check("R7 disable", irq, 0);
    repeat (3) @(negedge clk);
    check("R7 stays low", irq, 0);
    fault_f = 1'b0;
  endtask

  task automatic t_pads;
    reg_write(8'h40);
    pad_out = 4'b0110;
    #1;
    check("R8 oe", pad_oe, 4'b1111);
    check("R8 data", pad, 4'b0110);
    pad_out = 4'b1001;
    #1;
    check("R8 data2", pad, 4'b1001);
    reg_write(8'h60);
    pad_out = 4'b0110;
    #1;
    check("R9 oe", pad_oe, 4'b1001);
    check("R9 data", pad, 0);
    pad_out = 4'b1100;
    #1;
    check("R9 oe2", pad_oe, 4'b0011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_divide(0);
    t_divide(1);
    t_divide(2);
    t_divide(3);
    t_divide(5);
    t_divide(7);
    t_restart();
    t_disabled();
    t_irq();
    t_pads();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule